// File: doc/BRIEF.md
# MIDI Note Event Serializer

This block takes one note event at a time through a request/ready handshake and sends it out as a three-byte MIDI channel message on a single asynchronous serial line. An event carries a channel (0 to 15), a note number, a velocity and an on/off flag. The block packs the event type and channel into a status byte, follows it with the note and velocity as 7-bit data bytes, and shifts the 30 resulting line bits out least significant bit first at the MIDI line rate.

The bit period comes from the system clock through a divider whose count is the system clock frequency over the line rate, rounded to the nearest integer. The line rests high whenever no message is in flight. A new request is taken only while ready is high; the event fields are captured in that cycle, so the requester may change them or drop the request straight afterwards.

Top module: `midi_note_serializer`

## Requirements
- R1: Whenever ready is high, including straight after reset, the serial output is high and no message is in flight.
- R2: Every byte goes out as one low start bit, eight data bits least significant first, then one high stop bit, each bit held for exactly DIV clock cycles.
- R3: DIV equals CLK_HZ divided by BAUD rounded to the nearest integer (BAUD defaults to 31250), and DIV times BAUD lies within 1% of CLK_HZ.
- R4: The status byte carries 0x9 in its upper four bits for a note-on event and 0x8 for a note-off event, and the channel number in its lower four bits.
- R5: The three bytes leave in the order status, note, velocity; note 0x3C with velocity 0x34 on channel 0 as note-on gives 0x90, 0x3C, 0x34.
- R6: Bit 7 of the note byte and of the velocity byte is always sent as 0, whatever the request carried in that bit.
- R7: Ready drops in the cycle after a request is taken and rises again exactly 30 times DIV cycles after the acceptance edge, when the third stop bit has completed.
- R8: A request presented while ready is low is ignored, and field changes after acceptance do not alter the message being sent.
- R9: The three bytes follow each other with no idle bit: each start bit begins right where the previous stop bit ends.
- R10: The first start bit appears on the line in the cycle right after the acceptance edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Event request |
| req_ready | output | 1 | High when a request can be taken |
| req_chan | input | 4 | Channel number 0 to 15 |
| req_note | input | 8 | Note number, bit 7 ignored |
| req_vel | input | 8 | Velocity, bit 7 ignored |
| req_on | input | 1 | 1 for note-on, 0 for note-off |
| tx_out | output | 1 | Serial line, idles high |

## Verification
The bound checks assume the requester obeys the handshake in the usual way: a transfer is the cycle where request and ready are both high, and inputs are stable around the clock edge. They also rely on reset being applied before the first request, so the phase and length counters in the checker start aligned with the design. The stimulus drives all inputs half a period away from the active edge, raises a request only after seeing ready high, and deliberately waves requests and changing fields during a busy message to show they have no effect, which the assumptions permit.

// File: rtl/midi_ser_pkg.sv
package midi_ser_pkg;

    localparam int unsigned MSG_BYTES  = 3;
    localparam int unsigned BYTE_BITS  = 10;
    localparam int unsigned FRAME_BITS = MSG_BYTES * BYTE_BITS;

    localparam logic [3:0] NIB_NOTE_ON  = 4'h9;
    localparam logic [3:0] NIB_NOTE_OFF = 4'h8;

    function automatic int unsigned bit_div(input int unsigned clk_hz, input int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/midi_ser_baud.sv
module midi_ser_baud #(
    parameter int unsigned DIV = 6400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick = en;
        end else begin : g_cnt
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                tick  = en && (cnt_q == LAST);
                cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end
        end
    endgenerate
endmodule

// File: rtl/midi_ser_frame.sv
module midi_ser_frame
    import midi_ser_pkg::*;
(
    input  logic [3:0]            chan,
    input  logic [7:0]            note,
    input  logic [7:0]            vel,
    input  logic                  on,
    output logic [FRAME_BITS-1:0] frame
);
    logic [7:0] msg_byte [MSG_BYTES];

    always_comb begin
        msg_byte[0] = {(on ? NIB_NOTE_ON : NIB_NOTE_OFF), chan};
        msg_byte[1] = note & 8'h7F;
        msg_byte[2] = vel & 8'h7F;
    end

    genvar gi;
    generate
        for (gi = 0; gi < MSG_BYTES; gi++) begin : g_byte
            assign frame[gi*BYTE_BITS +: BYTE_BITS] = {1'b1, msg_byte[gi], 1'b0};
        end
    endgenerate
endmodule

// File: rtl/midi_note_serializer.sv
module midi_note_serializer
    import midi_ser_pkg::*;
#(
    parameter int unsigned CLK_HZ = 200_000_000,
    parameter int unsigned BAUD   = 31250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [3:0] req_chan,
    input  logic [7:0] req_note,
    input  logic [7:0] req_vel,
    input  logic       req_on,
    output logic       tx_out
);
    localparam int unsigned DIV = bit_div(CLK_HZ, BAUD);
    localparam int unsigned IW  = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [FRAME_BITS-1:0] shift;
        logic [IW-1:0]         idx;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic [FRAME_BITS-1:0] frame_w;
    logic tick_w;

    midi_ser_frame u_frame (
        .chan  (req_chan),
        .note  (req_note),
        .vel   (req_vel),
        .on    (req_on),
        .frame (frame_w)
    );

    midi_ser_baud #(.DIV(DIV)) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (st_q.busy),
        .tick  (tick_w)
    );

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy  = 1'b1;
                st_d.shift = frame_w;
                st_d.idx   = '0;
            end
        end else if (tick_w) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.shift = st_q.shift >> 1;
                st_d.idx   = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready = !st_q.busy;
    assign tx_out    = st_q.busy ? st_q.shift[0] : 1'b1;
endmodule

// File: rtl/midi_note_serializer_chk.sv
module midi_note_serializer_chk
    import midi_ser_pkg::*;
#(
    parameter int unsigned CLK_HZ = 200_000_000,
    parameter int unsigned BAUD   = 31250
) (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic tx_out
);
    localparam int unsigned DIV = bit_div(CLK_HZ, BAUD);
    localparam int unsigned MSG_CYC = FRAME_BITS * DIV;

    int unsigned ph_q;
    int unsigned busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q       <= 0;
            busy_cnt_q <= 0;
        end else if (req_valid && req_ready) begin
            ph_q       <= 0;
            busy_cnt_q <= 0;
        end else if (!req_ready) begin
            ph_q       <= (ph_q == DIV - 1) ? 0 : ph_q + 1;
            busy_cnt_q <= busy_cnt_q + 1;
        end
    end

    initial begin
        assert_rate_tol_R3: assert ((DIV * BAUD > CLK_HZ ? DIV * BAUD - CLK_HZ : CLK_HZ - DIV * BAUD) * 100 <= CLK_HZ);
    end

    assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> tx_out);

    assert_accept_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !tx_out));

    assert_bit_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && $past(!req_ready) && (tx_out != $past(tx_out))) |-> ($past(ph_q) == DIV - 1));

    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> (busy_cnt_q == MSG_CYC));

    assert_last_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_ready) |-> $past(tx_out));
endmodule

bind midi_note_serializer midi_note_serializer_chk #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .tx_out    (tx_out)
);

// File: tb/midi_note_serializer_tb.sv
`timescale 1ns/1ps
module midi_note_serializer_tb;
    localparam int unsigned CLK_HZ = 250_000;
    localparam int unsigned BAUD   = 31250;
    localparam int unsigned DIV    = 8;   // R3: 250000 / 31250 rounded
    localparam int unsigned MSG_CYC = 30 * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [3:0] req_chan = '0;
    logic [7:0] req_note = '0;
    logic [7:0] req_vel = '0;
    logic req_on = 1'b0;
    logic req_ready, tx_out;

    int n_chk = 0;
    int n_fail = 0;
    int n_frames = 0;
    int n_sent = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    midi_note_serializer #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_note(req_note), .req_vel(req_vel),
        .req_on(req_on), .tx_out(tx_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    // Driver: pushes expected bytes, then drives the handshake and times ready.
    task automatic send(input logic [3:0] ch, input logic [7:0] nt, input logic [7:0] vl,
                        input logic on, input bit poke_busy);
        int cnt;
        while (!req_ready) @(negedge clk);
        req_chan = ch; req_note = nt; req_vel = vl; req_on = on; req_valid = 1'b1;
        exp_q.push_back({(on ? 4'h9 : 4'h8), ch}); tag_q.push_back("R4 R5 status");
        exp_q.push_back(nt & 8'h7F);               tag_q.push_back("R5 R6 note");
        exp_q.push_back(vl & 8'h7F);               tag_q.push_back("R5 R6 velocity");
        n_sent++;
        @(negedge clk);
        check(req_ready == 1'b0, "R7 ready low after accept", req_ready, 0);
        check(tx_out == 1'b0, "R10 start bit next cycle", tx_out, 0);
        cnt = 0;
        if (poke_busy) begin
            // R8: requests and field changes while busy must be ignored
            req_chan = ~ch; req_note = ~nt; req_vel = ~vl; req_on = ~on;
            repeat (20) begin @(negedge clk); cnt++; end
            req_valid = 1'b0;
        end else begin
            req_valid = 1'b0;
            req_chan = 4'h3; req_note = 8'h11; req_vel = 8'h22;
        end
        while (!req_ready) begin @(negedge clk); cnt++; end
        check(cnt == MSG_CYC, "R7 busy length", cnt, MSG_CYC);
        check(tx_out == 1'b1, "R1 idle high after message", tx_out, 1);
    endtask

    // Monitor: decodes the line at mid-bit without resynchronising inside a message.
    initial begin
        logic [7:0] data;
        forever begin
            @(negedge clk);
            if (rst_n && tx_out === 1'b0) begin
                repeat (DIV / 2) @(negedge clk);
                for (int b = 0; b < 3; b++) begin
                    check(tx_out == 1'b0, b == 0 ? "R2 start bit" : "R9 back-to-back start", tx_out, 0);
                    data = '0;
                    for (int i = 0; i < 8; i++) begin
                        repeat (DIV) @(negedge clk);
                        data[i] = tx_out;
                    end
                    repeat (DIV) @(negedge clk);
                    check(tx_out == 1'b1, "R2 stop bit", tx_out, 1);
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R8 unexpected byte", data, 0);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        check(data == e, t, data, e);
                    end
                    if (b < 2) repeat (DIV) @(negedge clk);
                end
                n_frames++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_frames, n_sent);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in reset", req_ready, 1);
        check(tx_out == 1'b1, "R1 line high in reset", tx_out, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && tx_out == 1'b1, "R1 after reset", {req_ready, tx_out}, 3);

        send(4'h0, 8'h3C, 8'h34, 1'b1, 1'b0);   // R5 example 90 3C 34
        send(4'hF, 8'h7F, 8'h00, 1'b0, 1'b0);   // R4 off, channel 15
        send(4'h5, 8'hFF, 8'h80, 1'b1, 1'b1);   // R6 masking, R8 poke while busy
        send(4'hA, 8'h01, 8'h7F, 1'b0, 1'b1);   // R8 again, R2 alternating data
        send(4'h1, 8'h55, 8'h2A, 1'b1, 1'b0);

        repeat (MSG_CYC + 20) @(negedge clk);
        check(exp_q.size() == 0, "R8 all expected bytes seen", exp_q.size(), 0);
        check(n_frames == n_sent, "R8 message count", n_frames, n_sent);
        check(req_ready == 1'b1 && tx_out == 1'b1, "R1 final idle", {req_ready, tx_out}, 3);
        report();
    end
endmodule